// File: doc/BRIEF.md
# 18-bit Four-Lane Serial Pixel Transmitter

This block takes one 18-bit pixel (three 6-bit colour components) plus the horizontal sync, vertical sync and data-enable flags. It turns each pixel into three 7-bit data lane words and a 7-bit clock-lane word. The four words are shifted out one bit per fast clock, so every lane sends seven bits per pixel period. The serial outputs are single-ended and go to external differential drivers.

Everything runs on the fast serial clock. An internal phase counter divides that clock by seven. Once per period it raises `pix_take` for one cycle. The upstream pixel source must present the next pixel during that cycle. The pixel is registered at the closing edge and moved into the shift registers at the word boundary that follows. The clock lane then carries the recovered pixel clock as the repeating pattern 1,1,0,0,0,1,1. An output enable forces all four serial outputs low, for example while the panel's logic supply is off.

Top module: `lvds18_tx`

## Requirements
- R1: Data lane 0 sends, in time order, red bit 0 to red bit 5 (LSB first), then green bit 0.
- R2: Data lane 1 sends, in time order, green bit 1 to green bit 5, then blue bit 0, then blue bit 1.
- R3: Data lane 2 sends, in time order, blue bit 2 to blue bit 5, then the horizontal sync, the vertical sync and the data-enable flags.
- R4: The clock lane sends the 7-bit sequence 1,1,0,0,0,1,1 in every pixel period, aligned to the first bit of the data words.
- R5: `pix_take` is high for exactly one clock in every seven. The pixel inputs are sampled only at the rising edge that ends a `pix_take` cycle, and their values at any other time have no effect on the serial outputs.
- R6: Bit 0 of a captured pixel appears on the lanes during the clock after the second rising edge that follows the start of its `pix_take` cycle. The remaining bits follow one per clock.
- R7: While `out_en` is low, all four serial outputs are 0. Raising `out_en` again restores correct words without losing word alignment.
- R8: While `rst_n` is low, all serial outputs and `pix_take` are 0. The first `pix_take` is seen in the clock after the sixth rising edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial bit clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 1 | Active-high enable for all serial outputs |
| red | input | 6 | Red component, bit 5 is MSB |
| grn | input | 6 | Green component, bit 5 is MSB |
| blu | input | 6 | Blue component, bit 5 is MSB |
| hsync | input | 1 | Horizontal sync flag |
| vsync | input | 1 | Vertical sync flag |
| den | input | 1 | Data-enable flag |
| pix_take | output | 1 | High in the cycle whose closing edge samples the pixel inputs |
| lane_d | output | 3 | Serial data lanes 2..0 |
| lane_clk | output | 1 | Serial clock-lane pattern |

## Verification
The bench first drives pixels whose bits differ across lane boundaries: green bit 0 against green bit 1, and blue bit 1 against blue bit 2. A design that moved a bit into a neighbouring lane, or reversed the order within a lane, would then emit a wrong word. It also holds the complement of the pixel on the inputs at every edge other than the sampling edge. A block that sampled late or early would then shift out inverted bits.

The bench collects bits exactly one clock after the load edge, so a design with an extra or missing pipeline stage shows up as a rotated word. A frame is also sent with the output enable low, and the next frame after re-enabling must still be aligned. A gate placed in the wrong spot would leave a lane toggling, and a counter reset by the enable would break the 1-in-7 strobe spacing.

// File: rtl/lvds18_pkg.sv
package lvds18_pkg;
  localparam int COMP_W     = 6;
  localparam int LANE_W     = 7;
  localparam int DATA_LANES = 3;
  localparam int ALL_LANES  = DATA_LANES + 1;
  localparam int STREAM_W   = DATA_LANES * LANE_W;

  localparam logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic              de;
    logic              vs;
    logic              hs;
    logic [COMP_W-1:0] b;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] r;
  } pix_t;

  // Time-ordered bit stream: R0..R5, G0..G5, B0..B5, HS, VS, DE.
  // Lane n takes the n-th group of seven from this stream, bit 0 first.
  function automatic logic [LANE_W-1:0] lane_word(input int unsigned idx, input pix_t p);
    logic [STREAM_W-1:0] stream;
    stream = {p.de, p.vs, p.hs, p.b, p.g, p.r};
    return stream[idx*LANE_W +: LANE_W];
  endfunction
endpackage

// File: rtl/lvds18_phase.sv
module lvds18_phase #(
  parameter int WORD = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(WORD)-1:0] ph,
  output logic                    take,
  output logic                    load
);
  localparam int PH_W = $clog2(WORD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)             ph <= '0;
    else if (ph == PH_LAST) ph <= '0;
    else                    ph <= ph + 1'b1;
  end

  assign take = (ph == PH_LAST);
  assign load = (ph == '0);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ph == '0));                                        // R5
  AST_TAKE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> load && !take);                                     // R5
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_LAST);                                              // R5
endmodule

// File: rtl/lvds18_capture.sv
module lvds18_capture
  import lvds18_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               take,
  input  pix_t                               pix_in,
  output logic [DATA_LANES-1:0][LANE_W-1:0]  words
);
  for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)    words[i] <= '0;
      else if (take) words[i] <= lane_word(i, pix_in);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(words));                                   // R5
endmodule

// File: rtl/lvds18_shifter.sv
module lvds18_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         bit_out
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n)    sreg <= '0;
    else if (load) sreg <= word;
    else           sreg <= {1'b0, sreg[W-1:1]};
  end

  assign bit_out = sreg[0];

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sreg == $past(word)));                             // R6
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sreg[W-2:0] == $past(sreg[W-1:1])));              // R6
endmodule

// File: rtl/lvds18_tx.sv
module lvds18_tx
  import lvds18_pkg::*;
(
  input  logic                  clk_ser,
  input  logic                  rst_n,
  input  logic                  out_en,
  input  logic [COMP_W-1:0]     red,
  input  logic [COMP_W-1:0]     grn,
  input  logic [COMP_W-1:0]     blu,
  input  logic                  hsync,
  input  logic                  vsync,
  input  logic                  den,
  output logic                  pix_take,
  output logic [DATA_LANES-1:0] lane_d,
  output logic                  lane_clk
);
  localparam int PH_W = $clog2(LANE_W);

  logic [PH_W-1:0]                   ph;
  logic                              take;
  logic                              load;
  pix_t                              pix;
  logic [DATA_LANES-1:0][LANE_W-1:0] held;
  logic [ALL_LANES-1:0]              ser_bit;

  assign pix = '{de: den, vs: vsync, hs: hsync, b: blu, g: grn, r: red};

  lvds18_phase #(.WORD(LANE_W)) u_phase (
    .clk (clk_ser), .rst_n (rst_n), .ph (ph), .take (take), .load (load)
  );

  lvds18_capture u_capture (
    .clk (clk_ser), .rst_n (rst_n), .take (take), .pix_in (pix), .words (held)
  );

  for (genvar i = 0; i < ALL_LANES; i++) begin : g_ser
    logic [LANE_W-1:0] src;
    if (i < DATA_LANES) begin : g_data
      assign src = held[i];
    end else begin : g_clk
      assign src = CLK_PATTERN;
    end
    lvds18_shifter #(.W(LANE_W)) u_sh (
      .clk (clk_ser), .rst_n (rst_n), .load (load), .word (src), .bit_out (ser_bit[i])
    );
  end

  assign pix_take = take;
  assign lane_d   = ser_bit[DATA_LANES-1:0] & {DATA_LANES{out_en}};
  assign lane_clk = ser_bit[DATA_LANES] & out_en;

  AST_CLK_LEAD_HIGH: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (out_en && ph == PH_W'(1)) |-> lane_clk);                    // R4
  AST_CLK_MID_LOW: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (out_en && ph == PH_W'(3)) |-> !lane_clk);                   // R4
  AST_QUIET_OFF: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !out_en |-> (lane_d == '0 && !lane_clk));                    // R7
endmodule

// File: tb/sim_lvds18_tx.sv
module sim_lvds18_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       out_en = 1'b1;
  logic [5:0] red = '0, grn = '0, blu = '0;
  logic       hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic       pix_take;
  logic [2:0] lane_d;
  logic       lane_clk;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [6:0] got [4];

  localparam logic [6:0] CLK_SEQ = 7'b1100011;

  // vector layout: [20]=DE [19]=VS [18]=HS [17:12]=B [11:6]=G [5:0]=R
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 6'h00, 6'h00, 6'h00},
    {1'b0, 1'b1, 1'b1, 6'h3F, 6'h3F, 6'h3F},
    {1'b1, 1'b0, 1'b1, 6'h2A, 6'h15, 6'h2A},
    {1'b0, 1'b1, 1'b0, 6'h03, 6'h01, 6'h20},
    {1'b1, 1'b1, 1'b1, 6'h3C, 6'h3E, 6'h01},
    {1'b0, 1'b0, 1'b0, 6'h01, 6'h02, 6'h00},
    {1'b1, 1'b0, 1'b0, 6'h04, 6'h00, 6'h10},
    {1'b0, 1'b0, 1'b1, 6'h12, 6'h2D, 6'h0B}
  };

  lvds18_tx u0 (
    .clk_ser (clk), .rst_n (rst_n), .out_en (out_en),
    .red (red), .grn (grn), .blu (blu),
    .hsync (hsync), .vsync (vsync), .den (den),
    .pix_take (pix_take), .lane_d (lane_d), .lane_clk (lane_clk)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [20:0] v);
    red = v[5:0]; grn = v[11:6]; blu = v[17:12];
    hsync = v[18]; vsync = v[19]; den = v[20];
  endtask

  function automatic logic exp_bit(input int lane, input int k, input logic [20:0] v);
    logic [5:0] r, g, b;
    r = v[5:0]; g = v[11:6]; b = v[17:12];
    case (lane)
      0:       return (k < 6) ? r[k] : g[0];
      1:       return (k < 5) ? g[k+1] : b[k-5];
      default: begin
        if (k < 4)  return b[k+2];
        if (k == 4) return v[18];
        if (k == 5) return v[19];
        return v[20];
      end
    endcase
  endfunction

  function automatic logic [6:0] exp_word(input int lane, input logic [20:0] v);
    logic [6:0] w;
    for (int k = 0; k < 7; k++) w[k] = exp_bit(lane, k, v);
    return w;
  endfunction

  // Send one pixel and collect the seven bits of each lane (R6 timing).
  task automatic frame(input logic [20:0] v, input bit scramble);
    if (scramble) drive(~v);
    @(negedge clk);
    while (pix_take !== 1'b1) @(negedge clk);
    drive(v);
    @(posedge clk);            // capture edge
    if (scramble) begin #1 drive(~v); end
    @(posedge clk);            // load edge
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      got[0][k] = lane_d[0];
      got[1][k] = lane_d[1];
      got[2][k] = lane_d[2];
      got[3][k] = lane_clk;
      if (k < 6) @(posedge clk);
    end
  endtask

  task automatic check_frame(input logic [20:0] v, input string tag);
    check(got[0] == exp_word(0, v), "R1", {tag, " lane0"}, got[0], exp_word(0, v));
    check(got[1] == exp_word(1, v), "R2", {tag, " lane1"}, got[1], exp_word(1, v));
    check(got[2] == exp_word(2, v), "R3", {tag, " lane2"}, got[2], exp_word(2, v));
    check(got[3] == CLK_SEQ, "R4", {tag, " clock lane"}, got[3], CLK_SEQ);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(lane_d == 3'b000 && lane_clk == 1'b0, "R8", "outputs in reset",
          {lane_d, lane_clk}, 0);
    check(pix_take == 1'b0, "R8", "pix_take in reset", pix_take, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (pix_take !== 1'b1 && n < 20);
    check(n == 6, "R8", "cycles to first pix_take", n, 6);
    // R5: strobe period
    n = 0;
    do begin @(negedge clk); n++; end while (pix_take !== 1'b1 && n < 20);
    check(n == 7, "R5", "pix_take period", n, 7);

    // table walk: R1..R4, R6
    for (int i = 0; i < 8; i++) begin
      frame(VEC[i], 1'b0);
      check_frame(VEC[i], $sformatf("R6 vec%0d", i));
    end

    // R5: inputs outside the sampling edge have no effect
    frame(VEC[2], 1'b1);
    check_frame(VEC[2], "R5 scrambled vec2");
    frame(VEC[7], 1'b1);
    check_frame(VEC[7], "R5 scrambled vec7");

    // R7: output enable low silences all lanes
    out_en = 1'b0;
    frame(VEC[1], 1'b0);
    check(got[0] == 0 && got[1] == 0 && got[2] == 0, "R7", "data lanes off",
          {got[2], got[1], got[0]}, 0);
    check(got[3] == 0, "R7", "clock lane off", got[3], 0);
    out_en = 1'b1;
    frame(VEC[4], 1'b0);
    check_frame(VEC[4], "R7 re-enabled");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule